// File: doc/BRIEF.md
# Byte-to-Nibble Banked RAM Bridge

This bridge lets a byte-oriented master use the thirteen bytes of scratch storage in a real-time clock. That storage exists only as 4-bit cells in two register banks that share one small address space. The master issues one byte read or write with a valid/ready request. The bridge then runs a fixed string of single-cycle register cycles on the downstream nibble port. It writes the mode register to switch to the bank holding the upper nibble, then accesses that nibble at the byte's address. It switches to the bank holding the lower nibble and accesses that one. Last, it writes the mode register back to the normal timekeeping bank with the timer still enabled.

For a read, the two nibbles come back as one byte, upper half first. For a write, the byte is split the same way. A request for an address beyond the last byte ends at once with an error response and causes no downstream traffic. While a sequence runs, the bridge drops its ready and raises a busy flag, so any other master of the clock can tell the register port is taken.

Top module: `nib_ram_bridge`

## Requirements
- R1: Out of reset, and whenever no access is in progress, `req_ready` is 1, `busy` is 0, `rsp_valid` is 0, and neither downstream strobe is active.
- R2: An accepted request for byte address N (0 to 12) produces exactly five downstream cycles, one per clock, in the clocks directly after acceptance. In order they are: a write of 4'b1010 to address 13, an access at N, a write of 4'b1011 to address 13, an access at N, and a write of 4'b1001 to address 13. In each mode value, bit 3 is timer enable and bits 1:0 select the bank: 2 holds the upper nibbles, 3 holds the lower nibbles, and 1 is the normal bank.
- R3: For a write, the first access is a write strobe carrying `req_wdata[7:4]`, and the second is a write strobe carrying `req_wdata[3:0]`.
- R4: For a read, both accesses are read strobes. The device returns data on `dn_rdata` in the clock after each strobe. `rsp_rdata` is {first nibble, second nibble}.
- R5: A request with address 13, 14 or 15 gets its response in the first clock after acceptance, with `rsp_err` set, and causes no downstream strobe.
- R6: `rsp_valid` is high for exactly one clock, in the clock after the restore write, and `req_ready` returns to 1 in the following clock. `rsp_err` is 0 for in-range requests. `rsp_rdata` is 0 for writes and for errored requests.
- R7: From acceptance through the response clock, `req_ready` is 0 and `busy` is 1. Changes on `req_valid`, `req_write`, `req_addr` or `req_wdata` during that time do not alter the sequence or the response.
- R8: The read and write strobes are never active in the same clock.
- R9: Byte addresses 0 and 12 both behave as in-range addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Byte request present |
| req_ready | output | 1 | Bridge idle, request taken on this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Address was out of range |
| rsp_rdata | output | 8 | Byte read |
| busy | output | 1 | Downstream port in use |
| dn_wr | output | 1 | Downstream register write strobe |
| dn_rd | output | 1 | Downstream register read strobe |
| dn_addr | output | 4 | Downstream register address |
| dn_wdata | output | 4 | Downstream write nibble |
| dn_rdata | input | 4 | Downstream read nibble, valid the clock after `dn_rd` |

## Verification
The assertions assume that the device answers a read strobe on `dn_rdata` in the very next clock, and that nothing else drives the mode register between the bridge's own writes. The bench's device model registers its read data on the strobe edge and is the only thing on the port, so both assumptions hold. The assertions also assume that `req_valid` is sampled only on a clock where `req_ready` is high. The bench deliberately holds `req_valid` high and changes the address and data during a sequence, but it drops the request before the bridge returns to idle, so the bridge takes no unintended second request.

// File: rtl/nrb_pkg.sv
package nrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_HI,
        ST_ACC_HI,
        ST_SEL_LO,
        ST_ACC_LO,
        ST_RESTORE,
        ST_RESP
    } step_e;

    // mode-register field layout decoded by the clock device
    localparam int TIMER_BIT = 3;
    localparam int BANK_NORMAL = 1;
    localparam int BANK_UPPER  = 2;
    localparam int BANK_LOWER  = 3;

endpackage

// File: rtl/nrb_fsm.sv
module nrb_fsm
    import nrb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NUM_BYTES = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output step_e             step,
    output logic              accept,
    output logic              err
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

    typedef struct packed {
        step_e st;
        logic  err;
    } fsm_s;

    fsm_s cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        accept = (cur_q.st == ST_IDLE) && req_valid;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (req_addr > LAST_ADDR) begin
                        nxt_d.st  = ST_RESP;
                        nxt_d.err = 1'b1;
                    end else begin
                        nxt_d.st  = ST_SEL_HI;
                        nxt_d.err = 1'b0;
                    end
                end
            end
            ST_SEL_HI:  nxt_d.st = ST_ACC_HI;
            ST_ACC_HI:  nxt_d.st = ST_SEL_LO;
            ST_SEL_LO:  nxt_d.st = ST_ACC_LO;
            ST_ACC_LO:  nxt_d.st = ST_RESTORE;
            ST_RESTORE: nxt_d.st = ST_RESP;
            ST_RESP: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.err = 1'b0;
            end
            default:    nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= ST_IDLE;
            cur_q.err <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign step = cur_q.st;
    assign err  = cur_q.err;

endmodule

// File: rtl/nrb_datapath.sv
module nrb_datapath
    import nrb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NIB_W     = 4,
    parameter int MODE_ADDR = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  step_e               step,
    input  logic                accept,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*NIB_W-1:0]  req_wdata,
    input  logic [NIB_W-1:0]    dn_rdata,
    output logic                dn_wr,
    output logic                dn_rd,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic [NIB_W-1:0]    dn_wdata,
    output logic [2*NIB_W-1:0]  rdata
);
    localparam int BYTE_W = 2 * NIB_W;
    localparam logic [ADDR_W-1:0] MODE_REG = ADDR_W'(MODE_ADDR);
    localparam logic [NIB_W-1:0] W_UPPER   = NIB_W'((1 << TIMER_BIT) | BANK_UPPER);
    localparam logic [NIB_W-1:0] W_LOWER   = NIB_W'((1 << TIMER_BIT) | BANK_LOWER);
    localparam logic [NIB_W-1:0] W_NORMAL  = NIB_W'((1 << TIMER_BIT) | BANK_NORMAL);

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic [BYTE_W-1:0] rdata;
    } dp_s;

    dp_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (accept) begin
            nxt_d.is_wr = req_write;
            nxt_d.addr  = req_addr;
            nxt_d.wdata = req_wdata;
            nxt_d.rdata = '0;
        end
        // read data arrives one clock after each read strobe
        if (step == ST_SEL_LO && !cur_q.is_wr)
            nxt_d.rdata[BYTE_W-1:NIB_W] = dn_rdata;
        if (step == ST_RESTORE && !cur_q.is_wr)
            nxt_d.rdata[NIB_W-1:0] = dn_rdata;
    end

    always_comb begin
        dn_wr    = 1'b0;
        dn_rd    = 1'b0;
        dn_addr  = '0;
        dn_wdata = '0;
        unique case (step)
            ST_SEL_HI: begin
                dn_wr    = 1'b1;
                dn_addr  = MODE_REG;
                dn_wdata = W_UPPER;
            end
            ST_ACC_HI: begin
                dn_wr    = cur_q.is_wr;
                dn_rd    = !cur_q.is_wr;
                dn_addr  = cur_q.addr;
                dn_wdata = cur_q.is_wr ? cur_q.wdata[BYTE_W-1:NIB_W] : '0;
            end
            ST_SEL_LO: begin
                dn_wr    = 1'b1;
                dn_addr  = MODE_REG;
                dn_wdata = W_LOWER;
            end
            ST_ACC_LO: begin
                dn_wr    = cur_q.is_wr;
                dn_rd    = !cur_q.is_wr;
                dn_addr  = cur_q.addr;
                dn_wdata = cur_q.is_wr ? cur_q.wdata[NIB_W-1:0] : '0;
            end
            ST_RESTORE: begin
                dn_wr    = 1'b1;
                dn_addr  = MODE_REG;
                dn_wdata = W_NORMAL;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata = cur_q.rdata;

endmodule

// File: rtl/nib_ram_bridge.sv
module nib_ram_bridge
    import nrb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NIB_W     = 4,
    parameter int NUM_BYTES = 13,
    parameter int MODE_ADDR = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*NIB_W-1:0]  req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [2*NIB_W-1:0]  rsp_rdata,
    output logic                busy,
    output logic                dn_wr,
    output logic                dn_rd,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic [NIB_W-1:0]    dn_wdata,
    input  logic [NIB_W-1:0]    dn_rdata
);
    step_e step;
    logic  accept;
    logic  err;

    nrb_fsm #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .step      (step),
        .accept    (accept),
        .err       (err)
    );

    nrb_datapath #(
        .ADDR_W    (ADDR_W),
        .NIB_W     (NIB_W),
        .MODE_ADDR (MODE_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .accept    (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dn_rdata  (dn_rdata),
        .dn_wr     (dn_wr),
        .dn_rd     (dn_rd),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata),
        .rdata     (rsp_rdata)
    );

    assign req_ready = (step == ST_IDLE);
    assign busy      = (step != ST_IDLE);
    assign rsp_valid = (step == ST_RESP);
    assign rsp_err   = rsp_valid && err;

endmodule

// File: rtl/nrb_checker.sv
module nrb_checker
    import nrb_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int NIB_W     = 4,
    parameter int NUM_BYTES = 13,
    parameter int MODE_ADDR = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              busy,
    input logic              dn_wr,
    input logic              dn_rd,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [NIB_W-1:0]  dn_wdata
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);
    localparam logic [ADDR_W-1:0] MODE_REG  = ADDR_W'(MODE_ADDR);
    localparam logic [NIB_W-1:0]  W_UPPER   = NIB_W'((1 << TIMER_BIT) | BANK_UPPER);
    localparam logic [NIB_W-1:0]  W_NORMAL  = NIB_W'((1 << TIMER_BIT) | BANK_NORMAL);

    logic take;
    assign take = req_valid && req_ready;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!dn_wr && !dn_rd && !rsp_valid && !busy)); // R1

    AST_FIRST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_addr <= LAST_ADDR) |=> (dn_wr && dn_addr == MODE_REG && dn_wdata == W_UPPER)); // R2

    AST_RESTORE_BEFORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> $past(dn_wr && dn_addr == MODE_REG && dn_wdata == W_NORMAL)); // R2

    AST_ERR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_addr > LAST_ADDR) |=> (rsp_valid && rsp_err && !dn_wr && !dn_rd)); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !req_ready)); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_wr && dn_rd)); // R8

endmodule

bind nib_ram_bridge nrb_checker #(
    .ADDR_W    (ADDR_W),
    .NIB_W     (NIB_W),
    .NUM_BYTES (NUM_BYTES),
    .MODE_ADDR (MODE_ADDR)
) u_nrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .busy      (busy),
    .dn_wr     (dn_wr),
    .dn_rd     (dn_rd),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata)
);

// File: tb/nib_ram_bridge_bench.sv
`timescale 1ns/1ps
module nib_ram_bridge_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic       rsp_err;
    logic [7:0] rsp_rdata;
    logic       busy;
    logic       dn_wr;
    logic       dn_rd;
    logic [3:0] dn_addr;
    logic [3:0] dn_wdata;
    logic [3:0] dn_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nib_ram_bridge u_nib_ram_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .busy      (busy),
        .dn_wr     (dn_wr),
        .dn_rd     (dn_rd),
        .dn_addr   (dn_addr),
        .dn_wdata  (dn_wdata),
        .dn_rdata  (dn_rdata)
    );

    // behavioural banked nibble device
    logic [3:0] dev_mode = 4'h9;
    logic [3:0] dev_upper [16];
    logic [3:0] dev_lower [16];
    logic [7:0] ref_mem [16];

    initial begin
        for (int i = 0; i < 16; i++) begin
            dev_upper[i] = '0;
            dev_lower[i] = '0;
            ref_mem[i]   = '0;
        end
    end

    always @(posedge clk) begin
        if (dn_wr) begin
            if (dn_addr == 4'd13) dev_mode <= dn_wdata;
            else if (dev_mode[1:0] == 2'd2) dev_upper[dn_addr] <= dn_wdata;
            else if (dev_mode[1:0] == 2'd3) dev_lower[dn_addr] <= dn_wdata;
        end
        if (dn_rd) begin
            if (dev_mode[1:0] == 2'd2) dn_rdata <= dev_upper[dn_addr];
            else if (dev_mode[1:0] == 2'd3) dn_rdata <= dev_lower[dn_addr];
            else dn_rdata <= 4'hF;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] dn_bundle();
        return {dn_wr, dn_rd, (dn_wr || dn_rd) ? dn_addr : 4'h0, dn_wr ? dn_wdata : 4'h0};
    endfunction

    function automatic logic [9:0] mk_wr(input logic [3:0] a, input logic [3:0] d);
        return {1'b1, 1'b0, a, d};
    endfunction

    function automatic logic [9:0] mk_rd(input logic [3:0] a);
        return {1'b0, 1'b1, a, 4'h0};
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // one byte request; hold keeps req_valid high until the response clock
    task automatic do_req(input bit wr, input logic [3:0] a, input logic [7:0] d, input bit hold);
        logic [9:0] seq [$];
        bit         in_range;
        logic [7:0] exp_rd;
        in_range = (a <= 4'd12);
        @(negedge clk);
        chk("R1 ready before request", {31'd0, req_ready}, 32'd1);
        chk("R1 port quiet before request", {22'd0, dn_bundle()}, 32'd0);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (in_range) begin
            seq.push_back(mk_wr(4'd13, 4'b1010));
            seq.push_back(wr ? mk_wr(a, d[7:4]) : mk_rd(a));
            seq.push_back(mk_wr(4'd13, 4'b1011));
            seq.push_back(wr ? mk_wr(a, d[3:0]) : mk_rd(a));
            seq.push_back(mk_wr(4'd13, 4'b1001));
        end
        exp_rd = (!wr && in_range) ? ref_mem[a] : 8'h00;
        @(posedge clk);
        for (int k = 0; k < seq.size(); k++) begin
            @(negedge clk);
            if (k == 0) begin
                // R7: upstream changes mid-sequence are ignored
                req_valid = hold;
                req_write = ~wr;
                req_addr  = a ^ 4'h5;
                req_wdata = ~d;
            end
            chk(wr ? "R2 R3 downstream write step" : "R2 R4 downstream read step",
                {22'd0, dn_bundle()}, {22'd0, seq[k]});
            chk("R7 ready low while busy", {30'd0, req_ready, busy}, 32'd1);
            chk("R6 no early response", {31'd0, rsp_valid}, 32'd0);
        end
        @(negedge clk);
        if (!in_range) begin
            req_valid = hold;
            req_addr  = 4'd3;
        end
        chk(in_range ? "R6 response pulse" : "R5 error response",
            {30'd0, rsp_valid, rsp_err}, {30'd0, 1'b1, !in_range});
        chk(in_range ? "R5 port quiet at response" : "R5 no downstream cycle",
            {22'd0, dn_bundle()}, 32'd0);
        chk(wr ? "R6 write response data zero" : "R4 read byte", {24'd0, rsp_rdata}, {24'd0, exp_rd});
        chk("R7 ready low in response clock", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b0;
        if (wr && in_range) ref_mem[a] = d;
        @(negedge clk);
        chk("R6 ready back after response", {30'd0, req_ready, rsp_valid}, 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", {28'd0, req_ready, busy, rsp_valid, rsp_err}, 32'h8);
        chk("R1 reset strobes", {30'd0, dn_wr, dn_rd}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'd0, req_ready, dn_wr, dn_rd}, 32'h4);

        do_req(1'b1, 4'd0,  8'hA5, 1'b0);   // R9 lowest address
        do_req(1'b1, 4'd12, 8'h3C, 1'b0);   // R9 highest address
        do_req(1'b1, 4'd5,  8'h0F, 1'b0);
        do_req(1'b0, 4'd0,  8'h00, 1'b0);
        do_req(1'b0, 4'd12, 8'h00, 1'b0);
        do_req(1'b0, 4'd5,  8'h00, 1'b0);
        do_req(1'b1, 4'd7,  8'hE1, 1'b1);   // R7 valid held
        do_req(1'b0, 4'd7,  8'h00, 1'b1);
        do_req(1'b0, 4'd13, 8'h00, 1'b0);   // R5
        do_req(1'b1, 4'd15, 8'h77, 1'b0);   // R5
        do_req(1'b0, 4'd3,  8'h00, 1'b0);   // never written
        do_req(1'b1, 4'd7,  8'h5A, 1'b0);
        do_req(1'b0, 4'd7,  8'h00, 1'b0);
        do_req(1'b0, 4'd12, 8'h00, 1'b0);

        // device bank left on the normal bank with timer enabled (R2)
        chk("R2 device mode restored", {28'd0, dev_mode}, 32'h9);
        summary();
    end

endmodule